// File: doc/BRIEF.md
# Extended Capability List Walker

This block walks the chain of extended capability headers kept in a 4 KB configuration space. It reads that space through a synchronous port with a one-cycle read latency. A walk always begins at byte offset 0x100. At each header the block compares the capability ID with a requested ID, then follows the header's next pointer. It reports the offset where the ID was found, or zero, and in both cases the offset of the header visited just before the end of the walk.

The same engine also extends the chain. A requested ID that can never match takes the walk to the last header. In append mode the block then rewrites only the next-pointer field of that tail, so that it points at a caller-chosen offset, and writes a fresh header at that offset. A list that is empty, or malformed, or circular, ends the walk with an error instead of leaving it running forever.

Top module: `ecap_walker`

## Requirements
- R1: A header word holds the capability ID in bits 15:0, a 4-bit version in bits 19:16 and the next byte offset in bits 31:20. A match compares `req_id` with bits 15:0 only.
- R2: The first header read is at offset 0x100. If that word is all zeros, a search ends with `found_off`=0, `prev_off`=0 and `err`=0.
- R3: When the header at offset X matches, the result is `found_off`=X, and `prev_off` is the offset visited before X (0 when X is 0x100).
- R4: When the walk reaches a header whose next field is 0 without any match, the result is `found_off`=0 and `prev_off` is the offset of that last header.
- R5: A `req_id` with bit 16 set never matches, whatever its low 16 bits, so the search returns the list tail as in R4.
- R6: A next offset below 0x100, above 0xFF8 or not a multiple of 4 ends the walk with `err`=1. On every error `found_off` and `prev_off` are 0, and `mem_rd` never addresses a word outside that range.
- R7: At most MAX_HOPS headers are visited in one walk. A walk that needs more, such as a circular list, ends with `err`=1.
- R8: An append at offset 0x100 performs a single write of {12'h000, `new_ver`, `req_id[15:0]`} to 0x100 and returns `found_off`=0x100, `prev_off`=0.
- R9: An append at any other offset walks to the tail. It rewrites the tail word with bits 31:20 set to the new offset and bits 19:0 kept. It then writes the new header as in R8, and returns `found_off`=new offset, `prev_off`=tail.
- R10: An append whose offset is out of range or misaligned, by the rule of R6, or an append to an empty list at an offset other than 0x100, sets `err` and writes nothing.
- R11: `start` is accepted only while `busy` is low. `done` pulses for one cycle, and the results stay unchanged until the next accepted start. Latency from the start edge: 2 cycles per visited header plus 1. An append adds 2 cycles after the walk, an append at 0x100 takes 2 cycles, and a rejected append offset takes 1 cycle.
- R12: At most one memory access, either a read or a write, happens per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| append | input | 1 | 1 = append a header, 0 = search |
| req_id | input | 17 | Requested ID; bit 16 set means it can never match |
| new_off | input | 12 | Byte offset of the header to append |
| new_ver | input | 4 | Version field for the appended header |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| found_off | output | 12 | Offset of the match or of the appended header; 0 if none |
| prev_off | output | 12 | Offset of the predecessor or of the tail |
| err | output | 1 | The operation ended in error |
| mem_rd | output | 1 | Read strobe; data arrives the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 10 | Word address (byte offset / 4) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_rd` |

## Verification
Every result appears together with `done`, on the edge given by the R11 latency formula. That formula is 2 cycles per header visited plus one, with two more for the writes of an append. For each operation the bench counts falling edges from the start edge until `done` is seen. It compares that count with the number derived from the list shape, then reads the result ports. Memory effects are checked on the bench's own memory array after `done`, since both writes are complete by then.

// File: rtl/ecap_walker.sv
module ecap_walker #(
  parameter int MAX_HOPS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        append,
  input  logic [16:0] req_id,
  input  logic [11:0] new_off,
  input  logic [3:0]  new_ver,
  output logic        busy,
  output logic        done,
  output logic [11:0] found_off,
  output logic [11:0] prev_off,
  output logic        err,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [9:0]  mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam logic [11:0] BASE  = 12'h100;
  localparam logic [11:0] LAST  = 12'hFF8;
  localparam int          HOP_W = $clog2(MAX_HOPS + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_CHECK, S_LINK, S_NEW} st_t;

  st_t              st;
  logic [11:0]      cur, prv, off_q;
  logic [HOP_W-1:0] hops;
  logic [31:0]      tail_hdr;
  logic [16:0]      id_q;
  logic [3:0]       ver_q;
  logic             op_q;

  function automatic logic ok_off(input logic [11:0] o);
    return (o >= BASE) && (o <= LAST) && (o[1:0] == 2'b00);
  endfunction

  wire [11:0] h_next = mem_rdata[31:20];
  wire        hit    = !op_q && !id_q[16] && (mem_rdata[15:0] == id_q[15:0]);

  assign busy      = (st != S_IDLE);
  assign mem_rd    = (st == S_READ);
  assign mem_wr    = (st == S_LINK) || (st == S_NEW);
  assign mem_addr  = (st == S_NEW) ? off_q[11:2] : cur[11:2];
  assign mem_wdata = (st == S_LINK) ? {off_q, tail_hdr[19:0]}
                                    : {12'h000, ver_q, id_q[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; prv <= '0; off_q <= '0; hops <= '0;
      tail_hdr <= '0; id_q <= '0; ver_q <= '0; op_q <= 1'b0;
      done <= 1'b0; found_off <= '0; prev_off <= '0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          id_q <= req_id; op_q <= append; off_q <= new_off; ver_q <= new_ver;
          cur <= BASE; prv <= '0; hops <= '0;
          found_off <= '0; prev_off <= '0; err <= 1'b0;
          if (append && !ok_off(new_off)) begin
            err <= 1'b1; done <= 1'b1;
          end else if (append && new_off == BASE) begin
            st <= S_NEW;
          end else begin
            st <= S_READ;
          end
        end
        S_READ: st <= S_CHECK;
        S_CHECK: begin
          if (cur == BASE && mem_rdata == 32'h0) begin
            st <= S_IDLE; done <= 1'b1; err <= op_q;
          end else if (hit) begin
            st <= S_IDLE; done <= 1'b1; found_off <= cur; prev_off <= prv;
          end else if (h_next == 12'h000) begin
            if (op_q) begin
              tail_hdr <= mem_rdata; st <= S_LINK;
            end else begin
              st <= S_IDLE; done <= 1'b1; prev_off <= cur;
            end
          end else if (!ok_off(h_next) || hops == HOP_W'(MAX_HOPS - 1)) begin
            st <= S_IDLE; done <= 1'b1; err <= 1'b1;
          end else begin
            prv <= cur; cur <= h_next; hops <= hops + 1'b1; st <= S_READ;
          end
        end
        S_LINK: begin
          prv <= cur; st <= S_NEW;
        end
        S_NEW: begin
          st <= S_IDLE; done <= 1'b1; found_off <= off_q; prev_off <= prv;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [11:0] found_off,
  input logic [11:0] prev_off,
  input logic        err,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [9:0]  mem_addr
);
  p_one_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_start_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(found_off) && $stable(prev_off) && $stable(err)));
  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (found_off == 12'h0 && prev_off == 12'h0));
  p_found_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found_off != 12'h0) |->
      (found_off >= 12'h100 && found_off <= 12'hFF8 && found_off[1:0] == 2'b00));
  p_rd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_addr >= 10'h040 && mem_addr <= 10'h3FE));
endmodule

bind ecap_walker ecap_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .found_off(found_off), .prev_off(prev_off), .err(err),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr)
);

// File: tb/ecap_walker_bench.sv
`timescale 1ns/1ps
module ecap_walker_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, append = 1'b0;
  logic [16:0] req_id = '0;
  logic [11:0] new_off = '0;
  logic [3:0]  new_ver = '0;
  logic busy, done, err, mem_rd, mem_wr;
  logic [11:0] found_off, prev_off;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [1024];

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [11:0] r_found, r_prev;
  logic        r_err;
  int          r_lat;

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  ecap_walker #(.MAX_HOPS(8)) u_ecap_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .append(append), .req_id(req_id),
    .new_off(new_off), .new_ver(new_ver), .busy(busy), .done(done),
    .found_off(found_off), .prev_off(prev_off), .err(err), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hdr(input logic [11:0] off, input logic [15:0] id, input logic [3:0] v, input logic [11:0] nx);
    mem[off[11:2]] = {nx, v, id};
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  task automatic run(input logic op, input logic [16:0] id, input logic [11:0] off, input logic [3:0] v);
    @(negedge clk);
    append = op; req_id = id; new_off = off; new_ver = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_lat = 1;
    while (!done && r_lat < 400) begin
      @(negedge clk);
      r_lat++;
    end
    r_found = found_off; r_prev = prev_off; r_err = err;
  endtask

  task automatic expect_res(input string tag, input logic [11:0] f, input logic [11:0] p,
                            input logic e, input int lat);
    chk(r_found == f, {tag, " found"}, r_found, f);
    chk(r_prev == p, {tag, " prev"}, r_prev, p);
    chk(r_err == e, {tag, " err"}, r_err, e);
    if (lat > 0) chk(r_lat == lat, {tag, " latency R11"}, r_lat, lat);
  endtask

  typedef struct packed {
    logic [16:0] id;
    logic [11:0] f;
    logic [11:0] p;
    logic [7:0]  lat;
  } vec_t;

  // list: 0x100(id 1) -> 0x180(id B) -> 0x400(id 3, ver 2) -> end
  localparam vec_t VT [6] = '{
    '{17'h00001, 12'h100, 12'h000, 8'd3},   // R3 first element
    '{17'h0000B, 12'h180, 12'h100, 8'd5},   // R3
    '{17'h00003, 12'h400, 12'h180, 8'd7},   // R3 R1
    '{17'h00007, 12'h000, 12'h400, 8'd7},   // R4
    '{17'h1FFFF, 12'h000, 12'h400, 8'd7},   // R5
    '{17'h10003, 12'h000, 12'h400, 8'd7}    // R5 low bits equal a present ID
  };

  initial begin
    clr_mem();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && found_off == 0 && prev_off == 0 && !mem_rd && !mem_wr,
        "R11 reset state", {busy, done, err, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;

    hdr(12'h100, 16'h0001, 4'h1, 12'h180);
    hdr(12'h180, 16'h000B, 4'h1, 12'h400);
    hdr(12'h400, 16'h0003, 4'h2, 12'h000);
    for (int i = 0; i < 6; i++) begin
      run(1'b0, VT[i].id, 12'h0, 4'h0);
      expect_res("R3/R4/R5 table", VT[i].f, VT[i].p, 1'b0, int'(VT[i].lat));
    end

    // R11: start while busy is ignored
    @(negedge clk);
    append = 1'b0; req_id = 17'h3; start = 1'b1;
    @(negedge clk);
    append = 1'b1; req_id = 17'h1; new_off = 12'h202;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 5000) @(negedge clk);
    chk(found_off == 12'h400 && prev_off == 12'h180 && !err, "R11 start ignored while busy",
        found_off, 12'h400);

    // R2 empty list
    clr_mem();
    run(1'b0, 17'h1, 12'h0, 4'h0);
    expect_res("R2 empty", 12'h000, 12'h000, 1'b0, 3);

    // R10 append to empty list away from base
    run(1'b1, 17'h22, 12'h300, 4'h1);
    expect_res("R10 empty append", 12'h000, 12'h000, 1'b1, 3);
    chk(mem[12'h300 >> 2] == 0, "R10 no write", mem[12'h300 >> 2], 0);

    // R8 append at base
    run(1'b1, 17'h0010, 12'h100, 4'h3);
    expect_res("R8 append base", 12'h100, 12'h000, 1'b0, 2);
    chk(mem[12'h100 >> 2] == 32'h0003_0010, "R8 header word", mem[12'h100 >> 2], 32'h0003_0010);

    // R9 append after tail
    run(1'b1, 17'h0022, 12'h200, 4'h1);
    expect_res("R9 append", 12'h200, 12'h100, 1'b0, 5);
    chk(mem[12'h100 >> 2] == 32'h2003_0010, "R9 tail relinked", mem[12'h100 >> 2], 32'h2003_0010);
    chk(mem[12'h200 >> 2] == 32'h0001_0022, "R9 new header", mem[12'h200 >> 2], 32'h0001_0022);
    run(1'b0, 17'h22, 12'h0, 4'h0);
    expect_res("R9 find appended", 12'h200, 12'h100, 1'b0, 5);

    // R10 misaligned and out-of-range append offsets
    run(1'b1, 17'h0033, 12'h202, 4'h1);
    expect_res("R10 misaligned", 12'h000, 12'h000, 1'b1, 1);
    chk(mem[12'h200 >> 2] == 32'h0001_0022, "R10 tail untouched", mem[12'h200 >> 2], 32'h0001_0022);
    run(1'b1, 17'h0033, 12'h0FC, 4'h1);
    expect_res("R10 below base", 12'h000, 12'h000, 1'b1, 1);

    // R6 bad next pointers
    clr_mem();
    hdr(12'h100, 16'h0001, 4'h1, 12'h040);
    run(1'b0, 17'h9, 12'h0, 4'h0);
    expect_res("R6 next below base", 12'h000, 12'h000, 1'b1, 3);
    hdr(12'h100, 16'h0001, 4'h1, 12'h102);
    run(1'b0, 17'h9, 12'h0, 4'h0);
    expect_res("R6 next misaligned", 12'h000, 12'h000, 1'b1, 3);

    // R7 circular list, MAX_HOPS = 8
    hdr(12'h100, 16'h0001, 4'h1, 12'h140);
    hdr(12'h140, 16'h0002, 4'h1, 12'h100);
    run(1'b0, 17'h9, 12'h0, 4'h0);
    expect_res("R7 cycle", 12'h000, 12'h000, 1'b1, 17);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule